// File: doc/BRIEF.md
# Prefix-code segment expander with run replay

The block turns a serial stream of compressed bits back into fixed-width segments. Each segment is sent as a variable-length prefix code. A small coding table, written through a plain write port, maps each code to a segment value. Codes for segments that tend to come in unbroken runs carry a repeat flag. After such a code, the stream holds a count field of fixed width. The decoder then sends the segment out once plus as many extra times as the count says. A segment that comes back later, but not straight after itself, is simply sent again under its own code.

Bits enter one per accepted cycle on a valid/ready handshake. Segments leave on a second valid/ready handshake. Backpressure on the output holds both the run replay and the intake of bits, and no bit is lost. If a prefix reaches the longest allowed code length without matching a table entry, the decoder raises an error flag. It then drops every bit until a bit marked as start-of-frame arrives.

Top module: `rld_huff_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `err` is 0 and `in_ready` is 1, and every table entry is unused.
- R2: A table write with `tbl_we`=1 stores, at `tbl_addr`, a code length `tbl_len` (0 marks the entry unused), the code in the low `tbl_len` bits of `tbl_code`, the segment `tbl_seg` and the flag `tbl_rep`. Code bits arrive first bit first, and the first bit lands in bit `tbl_len`-1.
- R3: A matched code whose flag is 0 emits its segment exactly once.
- R4: A matched code whose flag is 1 is followed by CNT_W count bits, most significant first. The segment is then emitted count+1 times in a row, so a count of 0 emits it once.
- R5: The largest count (all ones) emits the segment 2^CNT_W times.
- R6: While `out_valid`=1 and `out_ready`=0, `out_seg` stays stable, `in_ready` is 0, and bits offered meanwhile are accepted later, after the run, without loss.
- R7: If MAX_LEN code bits match no entry, `err` rises and no segment is emitted. Later bits without `in_sof` are discarded, and `err` stays 1.
- R8: An accepted bit with `in_sof`=1 discards any partial code, count or error state, clears `err`, and becomes the first bit of a new code.
- R9: When several entries match the same prefix, the entry with the lowest address wins.
- R10: With B="0", A="10" and a flagged C="11", the stream 0,10,0,11,0010 yields B, A, B, C, C, C (A=0x42, B=0x43, C=0x44).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(ENTRIES) | Entry to write |
| tbl_len | input | $clog2(MAX_LEN+1) | Code length, 0 = unused |
| tbl_code | input | MAX_LEN | Code bits, right-aligned |
| tbl_seg | input | SEG_W | Segment value |
| tbl_rep | input | 1 | Repeat-count flag |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Input bit can be taken |
| in_bit | input | 1 | Stream bit |
| in_sof | input | 1 | Marks the bit as the start of a new code |
| out_valid | output | 1 | Segment offered |
| out_ready | input | 1 | Segment taken |
| out_seg | output | SEG_W | Decoded segment |
| err | output | 1 | Unmatched prefix seen, waiting for start-of-frame |

## Verification
The bench checks the zero count and the full count. A decoder that treats the count as the total number of copies would drop a segment in the first case. A counter one bit too narrow would cut the run short in the second. It stalls the output in the middle of a run while a further bit waits. A design that kept taking input during the stall, or that moved on to the next copy, would lose or duplicate data there. It also drives an unmatched prefix, a start-of-frame bit in the middle of a code, and duplicate table entries. A design that kept stale prefix bits, ignored the start-of-frame mark, or picked the wrong duplicate would emit the wrong segment.

// File: rtl/rld_pkg.sv
`timescale 1ns/1ps
package rld_pkg;
  typedef enum logic [1:0] {
    ST_CODE = 2'd0,
    ST_CNT  = 2'd1,
    ST_EMIT = 2'd2,
    ST_ERR  = 2'd3
  } rld_state_e;
endpackage

// File: rtl/rld_table.sv
`timescale 1ns/1ps
module rld_table #(
  parameter int ENTRIES = 8,
  parameter int MAX_LEN = 8,
  parameter int SEG_W   = 7,
  localparam int AW     = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [LEN_W-1:0]   wlen,
  input  logic [MAX_LEN-1:0] wcode,
  input  logic [SEG_W-1:0]   wseg,
  input  logic               wrep,
  input  logic [LEN_W-1:0]   probe_len,
  input  logic [MAX_LEN-1:0] probe_code,
  output logic               hit,
  output logic [SEG_W-1:0]   hit_seg,
  output logic               hit_rep
);
  logic [LEN_W-1:0]   len_q  [ENTRIES];
  logic [MAX_LEN-1:0] code_q [ENTRIES];
  logic [SEG_W-1:0]   seg_q  [ENTRIES];
  logic               rep_q  [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) len_q[i] <= '0;
    end else if (we) begin
      len_q[waddr] <= wlen;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      code_q[waddr] <= wcode;
      seg_q[waddr]  <= wseg;
      rep_q[waddr]  <= wrep;
    end
  end

  // One comparator per entry: only the low len bits take part.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [MAX_LEN-1:0] keep;
    always_comb begin
      keep = '0;
      for (int b = 0; b < MAX_LEN; b++)
        keep[b] = (b < int'(len_q[g]));
    end
    assign match[g] = (len_q[g] != '0) && (len_q[g] == probe_len) &&
                      (((code_q[g] ^ probe_code) & keep) == '0);
  end

  // Lowest address wins (R9).
  always_comb begin
    hit     = 1'b0;
    hit_seg = '0;
    hit_rep = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_seg = seg_q[i];
        hit_rep = rep_q[i];
      end
    end
  end

  p_wlen_ok_r2: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(wlen) <= MAX_LEN));
endmodule

// File: rtl/rld_ctrl.sv
`timescale 1ns/1ps
module rld_ctrl
  import rld_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int SEG_W   = 7,
  parameter int CNT_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CBW    = $clog2(CNT_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bit,
  input  logic               in_sof,
  output logic [LEN_W-1:0]   probe_len,
  output logic [MAX_LEN-1:0] probe_code,
  input  logic               hit,
  input  logic [SEG_W-1:0]   hit_seg,
  input  logic               hit_rep,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SEG_W-1:0]   out_seg,
  output logic               err
);
  rld_state_e         state;
  logic [LEN_W-1:0]   len_q;
  logic [MAX_LEN-1:0] pre_q;
  logic [CNT_W-1:0]   reps_q;
  logic [CBW-1:0]     cbits_q;
  logic [SEG_W-1:0]   seg_q;
  logic               take;
  logic [LEN_W-1:0]   base_len;
  logic [MAX_LEN-1:0] base_pre;

  assign in_ready  = (state != ST_EMIT);
  assign out_valid = (state == ST_EMIT);
  assign out_seg   = seg_q;
  assign take      = in_valid && in_ready;

  // A start-of-frame bit probes as if the prefix were empty.
  assign base_len   = in_sof ? '0 : len_q;
  assign base_pre   = in_sof ? '0 : pre_q;
  assign probe_len  = base_len + 1'b1;
  assign probe_code = {base_pre[MAX_LEN-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CODE;
      len_q   <= '0;
      pre_q   <= '0;
      reps_q  <= '0;
      cbits_q <= '0;
      seg_q   <= '0;
      err     <= 1'b0;
    end else if (state == ST_EMIT) begin
      if (out_ready) begin
        if (reps_q == '0) state <= ST_CODE;
        else              reps_q <= reps_q - 1'b1;
      end
    end else if (take) begin
      if (in_sof || state == ST_CODE) begin
        err <= 1'b0;
        if (hit) begin
          seg_q  <= hit_seg;
          len_q  <= '0;
          pre_q  <= '0;
          reps_q <= '0;
          if (hit_rep) begin
            state   <= ST_CNT;
            cbits_q <= '0;
          end else begin
            state <= ST_EMIT;
          end
        end else if (int'(probe_len) == MAX_LEN) begin
          state <= ST_ERR;
          err   <= 1'b1;
          len_q <= '0;
          pre_q <= '0;
        end else begin
          state <= ST_CODE;
          len_q <= probe_len;
          pre_q <= probe_code;
        end
      end else if (state == ST_CNT) begin
        reps_q  <= {reps_q[CNT_W-2:0], in_bit};
        cbits_q <= cbits_q + 1'b1;
        if (cbits_q == CBW'(CNT_W - 1)) state <= ST_EMIT;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seg)));
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);
  p_len_bound_r7: assert property (@(posedge clk) disable iff (rst)
    int'(len_q) < MAX_LEN);
  p_sof_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (take && in_sof) |=> !err);
endmodule

// File: rtl/rld_huff_decoder.sv
`timescale 1ns/1ps
module rld_huff_decoder #(
  parameter int ENTRIES = 8,
  parameter int MAX_LEN = 8,
  parameter int SEG_W   = 7,
  parameter int CNT_W   = 4,
  localparam int AW     = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [AW-1:0]      tbl_addr,
  input  logic [LEN_W-1:0]   tbl_len,
  input  logic [MAX_LEN-1:0] tbl_code,
  input  logic [SEG_W-1:0]   tbl_seg,
  input  logic               tbl_rep,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bit,
  input  logic               in_sof,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SEG_W-1:0]   out_seg,
  output logic               err
);
  logic [LEN_W-1:0]   probe_len;
  logic [MAX_LEN-1:0] probe_code;
  logic               hit;
  logic [SEG_W-1:0]   hit_seg;
  logic               hit_rep;

  rld_table #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .SEG_W(SEG_W)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wlen(tbl_len),
    .wcode(tbl_code), .wseg(tbl_seg), .wrep(tbl_rep),
    .probe_len(probe_len), .probe_code(probe_code),
    .hit(hit), .hit_seg(hit_seg), .hit_rep(hit_rep)
  );

  rld_ctrl #(.MAX_LEN(MAX_LEN), .SEG_W(SEG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .probe_len(probe_len),
    .probe_code(probe_code), .hit(hit), .hit_seg(hit_seg), .hit_rep(hit_rep),
    .out_valid(out_valid), .out_ready(out_ready), .out_seg(out_seg), .err(err)
  );
endmodule

// File: tb/rld_huff_decoder_bench.sv
`timescale 1ns/1ps
module rld_huff_decoder_bench;
  localparam logic [6:0] SA = 7'h42, SB = 7'h43, SC = 7'h44;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic [3:0] tbl_len = '0;
  logic [7:0] tbl_code = '0;
  logic [6:0] tbl_seg = '0;
  logic       tbl_rep = 1'b0;
  logic       in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0;
  logic       in_ready, out_valid, err;
  logic       out_ready = 1'b1;
  logic [6:0] out_seg;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [6:0] got[$];
  logic [6:0] exp_q[$];

  always #10 clk = ~clk;

  rld_huff_decoder u_rld_huff_decoder (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_len(tbl_len), .tbl_code(tbl_code), .tbl_seg(tbl_seg),
    .tbl_rep(tbl_rep), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_seg(out_seg), .err(err)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready) got.push_back(out_seg);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int l, input int c, input logic [6:0] s, input bit r);
    @(posedge clk); #2;
    tbl_we = 1'b1; tbl_addr = 3'(a); tbl_len = 4'(l);
    tbl_code = 8'(c); tbl_seg = s; tbl_rep = r;
    @(posedge clk); #2;
    tbl_we = 1'b0;
  endtask

  task automatic send_bit(input bit b, input bit sof);
    bit acc;
    @(posedge clk); #2;
    in_valid = 1'b1; in_bit = b; in_sof = sof;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk);
    end while (!acc);
    #2; in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(val[i], 1'b0);
  endtask

  task automatic expect_out(input string req, input int wait_cyc);
    repeat (wait_cyc) @(negedge clk);
    chk(got.size() == exp_q.size(), req, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], req, got[i], exp_q[i]);
    got.delete(); exp_q.delete();
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_example;
    send(0, 1); send(2, 2); send(0, 1); send(3, 2); send(2, 4);
    exp_q = '{SB, SA, SB, SC, SC, SC};
    expect_out("R10 R3 R4 example", 20);
  endtask

  task automatic t_zero_count;
    send(3, 2); send(0, 4); send(2, 2);
    exp_q = '{SC, SA};
    expect_out("R4 zero count", 20);
  endtask

  task automatic t_max_count;
    send(3, 2); send(15, 4);
    exp_q = '{SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC, SC};
    expect_out("R5 max count", 40);
  endtask

  task automatic t_backpressure;
    @(posedge clk); #2; out_ready = 1'b0;
    send(3, 2); send(3, 4);
    fork send_bit(1'b0, 1'b0); join_none
    repeat (5) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R6 valid held", out_valid, 1);
      chk(out_seg == SC, "R6 seg stable", out_seg, SC);
      chk(in_ready == 1'b0, "R6 input stalled", in_ready, 0);
    end
    chk(got.size() == 0, "R6 nothing taken", got.size(), 0);
    @(posedge clk); #2; out_ready = 1'b1;
    exp_q = '{SC, SC, SC, SC, SB};
    expect_out("R6 run then held bit", 30);
  endtask

  task automatic t_error_resync;
    wr(2, 0, 0, 7'h0, 1'b0);
    send(8'hFF, 8);
    @(negedge clk);
    chk(err == 1'b1, "R7 err raised", err, 1);
    send(0, 1);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R7 err kept", err, 1);
    exp_q.delete();
    expect_out("R7 no output", 2);
    send_bit(1'b0, 1'b1);
    @(negedge clk);
    chk(err == 1'b0, "R8 err cleared", err, 0);
    exp_q = '{SB};
    expect_out("R8 resync decode", 10);
    wr(2, 2, 3, SC, 1'b1);
  endtask

  task automatic t_sof_restart;
    send(1, 1);
    send_bit(1'b0, 1'b1);
    exp_q = '{SB};
    expect_out("R8 sof mid-code", 10);
    send(3, 2); send(1, 2);
    send_bit(1'b1, 1'b1); send(0, 1);
    exp_q = '{SA};
    expect_out("R8 sof mid-count", 10);
  endtask

  task automatic t_priority;
    wr(5, 1, 0, 7'h11, 1'b0);
    send(0, 1);
    exp_q = '{SB};
    expect_out("R9 lowest index", 10);
    wr(0, 0, 0, 7'h0, 1'b0);
    send(0, 1);
    exp_q = '{7'h11};
    expect_out("R2 R9 remaining entry", 10);
    wr(5, 0, 0, 7'h0, 1'b0);
    wr(0, 1, 0, SB, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    wr(0, 1, 0, SB, 1'b0);
    wr(1, 2, 2, SA, 1'b0);
    wr(2, 2, 3, SC, 1'b1);
    t_example();
    t_zero_count();
    t_max_count();
    t_backpressure();
    t_error_resync();
    t_sof_restart();
    t_priority();
    t_example();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule